// File: doc/BRIEF.md
# Next-PC and Exception Sequencer

This block owns the program counter of a single-cycle processor core. On every clock edge it loads a new PC. The new value comes from one of seven sources: the sequential address, a branch target, a jump target, a register target, or one of three fixed exception vectors. The decode logic, which sits outside this block, picks the source with a 3-bit select. A branch is presented as select 1 only when the branch condition holds. A branch or a jump that is not taken is presented as select 0.

The block has its own adder for the branch target. This leaves the main ALU free to do the compare subtraction in the same cycle. The block also drives a registered copy of PC+4, which the register file uses as the link value and as the return address saved on an exception.

Two asynchronous inputs arrive from outside the core: an interrupt request and an external reset request. Each one passes through a chain of flip-flops before it is used. Once synchronized, the reset request has priority over the interrupt request, and the interrupt request has priority over the decode select.

Top module: `pc_sequencer`

## Requirements
- R1: When neither synchronized request is active and `path_sel` is 0, the next PC is the current PC plus 4, wrapping modulo 2^32.
- R2: `pc_plus4` always equals `pc` + 4 (mod 2^32), and both outputs come from registers.
- R3: When `path_sel` is 1 and no request is active, the next PC is PC + 4 + (sign-extended `imm16` shifted left by 2), wrapping modulo 2^32. Bit 15 of `imm16` is the sign bit.
- R4: When `path_sel` is 2 and no request is active, the next PC is {bits 31:28 of PC+4, `jidx[25:0]`, 2'b00}.
- R5: When `path_sel` is 3 and no request is active, the next PC is `reg_target`, taken unchanged, including its two low bits.
- R6: With no request active, `path_sel` 4 loads 0x80000080 (interrupt vector), 5 loads 0x80000040 (illegal-opcode vector) and 6 loads 0x80000000 (reset vector). The value 7 is treated like 0.
- R7: When `rst` is high at a clock edge, the PC becomes 0x80000000, `pc_plus4` becomes 0x80000004, and both synchronizer chains are cleared.
- R8: `reset_async` passes through SYNC_STAGES flops (default 2). A level sampled high at edge k makes the PC 0x80000000 at edge k+SYNC_STAGES. The PC stays there for as long as the level is held, regardless of `irq_async` and `path_sel`.
- R9: `irq_async` passes through the same number of flops. While its synchronized level is high and the synchronized reset level is low, the PC loads 0x80000080 on every edge, regardless of `path_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| reset_async | input | 1 | Asynchronous external reset request, level |
| irq_async | input | 1 | Asynchronous interrupt request, level |
| path_sel | input | 3 | Next-PC source chosen by decode (0..7) |
| imm16 | input | 16 | Branch offset in words, two's complement |
| jidx | input | 26 | Word index field of a direct jump |
| reg_target | input | 32 | Register-sourced jump address |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current PC + 4, used for link and exception return |

## Verification
The hardest case to reach from the ports is a request that crosses the synchronizer on exactly the cycle that decode is asking for a branch, jump or register target. In that case the PC must follow the vector, not the target, and the target must take effect again only SYNC_STAGES edges after the request drops. The stimulus holds fixed non-zero selects while it raises and lowers the interrupt request, the reset request, and both together. It then runs a long random phase with sparse one-to-three-cycle request pulses. In every cycle the bench compares against a model that keeps its own queue of request samples.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Next-PC source codes as presented by decode; the numbering is fixed.
  typedef enum logic [2:0] {
    SRC_SEQ     = 3'd0,
    SRC_BRANCH  = 3'd1,
    SRC_JUMP    = 3'd2,
    SRC_REG     = 3'd3,
    SRC_IRQ     = 3'd4,
    SRC_ILLEGAL = 3'd5,
    SRC_RESET   = 3'd6
  } pc_src_e;

  localparam int ADDR_SHIFT = 2;  // word to byte address

endpackage

// File: rtl/pcseq_sync.sv
module pcseq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pcseq_targets.sv
module pcseq_targets
  import pcseq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_plus4,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   br_target,
  output logic [XLEN-1:0]   jmp_target
);

  localparam int EXT_W = XLEN - IMM_W - ADDR_SHIFT;
  localparam int HI_W  = XLEN - JIDX_W - ADDR_SHIFT;

  logic [XLEN-1:0] byte_offset;

  // The multiply by four is only wiring: two zero bits below the field.
  assign byte_offset = {{EXT_W{imm16[IMM_W-1]}}, imm16, {ADDR_SHIFT{1'b0}}};
  assign br_target   = pc_plus4 + byte_offset;
  assign jmp_target  = {pc_plus4[XLEN-1 -: HI_W], jidx, {ADDR_SHIFT{1'b0}}};

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
  import pcseq_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILLEGAL_VEC = 32'h8000_0040,
  parameter logic [XLEN-1:0] IRQ_VEC     = 32'h8000_0080
) (
  input  logic            reset_req,
  input  logic            irq_req,
  input  logic [2:0]      path_sel,
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] jmp_target,
  input  logic [XLEN-1:0] reg_target,
  output logic [XLEN-1:0] next_pc
);

  logic [XLEN-1:0] flow_pc;

  always_comb begin
    case (pc_src_e'(path_sel))
      SRC_BRANCH:  flow_pc = br_target;
      SRC_JUMP:    flow_pc = jmp_target;
      SRC_REG:     flow_pc = reg_target;
      SRC_IRQ:     flow_pc = IRQ_VEC;
      SRC_ILLEGAL: flow_pc = ILLEGAL_VEC;
      SRC_RESET:   flow_pc = RESET_VEC;
      default:     flow_pc = pc_plus4;
    endcase
  end

  // Synchronized requests override decode, reset first.
  always_comb begin
    if (reset_req)    next_pc = RESET_VEC;
    else if (irq_req) next_pc = IRQ_VEC;
    else              next_pc = flow_pc;
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int              XLEN        = 32,
  parameter int              IMM_W       = 16,
  parameter int              JIDX_W      = 26,
  parameter int              SYNC_STAGES = 2,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILLEGAL_VEC = 32'h8000_0040,
  parameter logic [XLEN-1:0] IRQ_VEC     = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reset_async,
  input  logic              irq_async,
  input  logic [2:0]        path_sel,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JIDX_W-1:0] jidx,
  input  logic [XLEN-1:0]   reg_target,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   pc_plus4
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            reset_sync;
  logic            irq_sync;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic [XLEN-1:0] next_pc;

  pcseq_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (2)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({irq_async, reset_async}),
    .q   ({irq_sync, reset_sync})
  );

  pcseq_targets #(
    .XLEN   (XLEN),
    .IMM_W  (IMM_W),
    .JIDX_W (JIDX_W)
  ) u_targets (
    .pc_plus4   (pc_plus4),
    .imm16      (imm16),
    .jidx       (jidx),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  pcseq_select #(
    .XLEN        (XLEN),
    .RESET_VEC   (RESET_VEC),
    .ILLEGAL_VEC (ILLEGAL_VEC),
    .IRQ_VEC     (IRQ_VEC)
  ) u_select (
    .reset_req  (reset_sync),
    .irq_req    (irq_sync),
    .path_sel   (path_sel),
    .pc_plus4   (pc_plus4),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .reg_target (reg_target),
    .next_pc    (next_pc)
  );

  // PC and its successor are both registered, so the link value has no adder
  // in front of the output.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RESET_VEC;
      pc_plus4 <= RESET_VEC + STEP;
    end else begin
      pc       <= next_pc;
      pc_plus4 <= next_pc + STEP;
    end
  end

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int              XLEN        = 32,
  parameter int              IMM_W       = 16,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILLEGAL_VEC = 32'h8000_0040,
  parameter logic [XLEN-1:0] IRQ_VEC     = 32'h8000_0080
) (
  input logic             clk,
  input logic             rst,
  input logic             reset_sync,
  input logic             irq_sync,
  input logic [2:0]       path_sel,
  input logic [IMM_W-1:0] imm16,
  input logic [XLEN-1:0]  reg_target,
  input logic [XLEN-1:0]  pc,
  input logic [XLEN-1:0]  pc_plus4
);

  localparam int EXT_W = XLEN - IMM_W - 2;

  logic quiet;
  assign quiet = !reset_sync && !irq_sync;

  // R1 and R6 (code 7): sequential step
  a_r1_seq_step: assert property (@(posedge clk) disable iff (rst)
    (quiet && (path_sel == 3'd0 || path_sel == 3'd7)) |=> pc == $past(pc) + XLEN'(4));

  // R2: link output tracks the PC
  a_r2_link_value: assert property (@(posedge clk) disable iff (rst)
    pc_plus4 == pc + XLEN'(4));

  // R3: branch target
  a_r3_branch_target: assert property (@(posedge clk) disable iff (rst)
    (quiet && path_sel == 3'd1) |=>
      pc == $past(pc_plus4 + {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00}));

  // R5: register target verbatim
  a_r5_reg_target: assert property (@(posedge clk) disable iff (rst)
    (quiet && path_sel == 3'd3) |=> pc == $past(reg_target));

  // R6: illegal-opcode vector
  a_r6_illegal_vec: assert property (@(posedge clk) disable iff (rst)
    (quiet && path_sel == 3'd5) |=> pc == ILLEGAL_VEC);

  // R8: synchronized reset request wins
  a_r8_reset_vec: assert property (@(posedge clk) disable iff (rst)
    reset_sync |=> pc == RESET_VEC);

  // R9: synchronized interrupt request beats decode
  a_r9_irq_vec: assert property (@(posedge clk) disable iff (rst)
    (!reset_sync && irq_sync) |=> pc == IRQ_VEC);

endmodule

bind pc_sequencer pcseq_checker #(
  .XLEN        (XLEN),
  .IMM_W       (IMM_W),
  .RESET_VEC   (RESET_VEC),
  .ILLEGAL_VEC (ILLEGAL_VEC),
  .IRQ_VEC     (IRQ_VEC)
) u_pcseq_checker (
  .clk        (clk),
  .rst        (rst),
  .reset_sync (reset_sync),
  .irq_sync   (irq_sync),
  .path_sel   (path_sel),
  .imm16      (imm16),
  .reg_target (reg_target),
  .pc         (pc),
  .pc_plus4   (pc_plus4)
);

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

  localparam int          SYNC = 2;
  localparam logic [31:0] RV   = 32'h8000_0000;
  localparam logic [31:0] EV   = 32'h8000_0040;
  localparam logic [31:0] IV   = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reset_async = 1'b0;
  logic        irq_async = 1'b0;
  logic [2:0]  path_sel = 3'd0;
  logic [15:0] imm16 = 16'd0;
  logic [25:0] jidx = 26'd0;
  logic [31:0] reg_target = 32'd0;
  logic [31:0] pc;
  logic [31:0] pc_plus4;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk         (clk),
    .rst         (rst),
    .reset_async (reset_async),
    .irq_async   (irq_async),
    .path_sel    (path_sel),
    .imm16       (imm16),
    .jidx        (jidx),
    .reg_target  (reg_target),
    .pc          (pc),
    .pc_plus4    (pc_plus4)
  );

  // Behavioural reference: queues of request samples and an integer PC.
  bit          rq[$];
  bit          iq[$];
  logic [31:0] m_pc = RV;
  string       m_tag = "R7";

  always @(posedge clk) begin
    logic [31:0] p4;
    if (rst) begin
      m_pc = RV;
      m_tag = "R7";
      rq = {};
      iq = {};
      for (int i = 0; i < SYNC; i++) begin rq.push_back(1'b0); iq.push_back(1'b0); end
    end else begin
      p4 = m_pc + 32'd4;
      if (rq[SYNC-1]) begin m_pc = RV; m_tag = "R8"; end
      else if (iq[SYNC-1]) begin m_pc = IV; m_tag = "R9"; end
      else begin
        case (path_sel)
          3'd0: begin m_pc = p4; m_tag = "R1"; end
          3'd1: begin m_pc = p4 + (32'($signed(imm16)) <<< 2); m_tag = "R3"; end
          3'd2: begin m_pc = {p4[31:28], jidx, 2'b00}; m_tag = "R4"; end
          3'd3: begin m_pc = reg_target; m_tag = "R5"; end
          3'd4: begin m_pc = IV; m_tag = "R6"; end
          3'd5: begin m_pc = EV; m_tag = "R6"; end
          3'd6: begin m_pc = RV; m_tag = "R6"; end
          default: begin m_pc = p4; m_tag = "R6"; end
        endcase
      end
      void'(rq.pop_back());
      void'(iq.pop_back());
      rq.push_front(reset_async);
      iq.push_front(irq_async);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock, then compare away from the edge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    check(m_tag, pc, m_pc);
    check("R2", pc_plus4, m_pc + 32'd4);
  endtask

  task automatic go(input logic [2:0] s, input int n);
    path_sel = s;
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R7: reset state
    go(3'd0, 3);
    rst = 1'b0;
    // R1: sequential flow
    go(3'd0, 3);
    // R3: positive, negative and most-negative offsets
    imm16 = 16'h0010; go(3'd1, 1);
    imm16 = 16'hFFF8; go(3'd1, 1);
    imm16 = 16'h8000; go(3'd1, 1);
    // R5: unaligned register target, then R4 jump keeps upper nibble
    reg_target = 32'h1234_5677; go(3'd3, 1);
    jidx = 26'h3AB_CDEF; go(3'd2, 1);
    // R1 wrap at the top of the address space
    reg_target = 32'hFFFF_FFFC; go(3'd3, 1);
    go(3'd0, 2);
    // R6: vectors and code 7
    go(3'd4, 1); go(3'd5, 1); go(3'd6, 1); go(3'd7, 2);
    // R9: interrupt level held with a branch select, then released
    imm16 = 16'h0004;
    irq_async = 1'b1; go(3'd1, 4);
    irq_async = 1'b0; go(3'd1, 4);
    // R8: reset request wins over interrupt and jump select
    reg_target = 32'h0000_1000;
    irq_async = 1'b1; reset_async = 1'b1; go(3'd3, 4);
    reset_async = 1'b0; go(3'd3, 3);
    irq_async = 1'b0; go(3'd3, 4);
    // R7: block reset in mid-run clears the synchronizers
    irq_async = 1'b1; go(3'd0, 1);
    rst = 1'b1; irq_async = 1'b0; go(3'd0, 1);
    rst = 1'b0; go(3'd0, 4);
    // Random phase with sparse request pulses
    for (int n = 0; n < 3000; n++) begin
      imm16 = 16'($urandom);
      jidx = 26'($urandom);
      reg_target = $urandom;
      reset_async = (($urandom % 40) == 0);
      irq_async = (($urandom % 12) == 0);
      go(3'($urandom), 1 + ($urandom % 3));
    end
    reset_async = 1'b0; irq_async = 1'b0;
    go(3'd0, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule